// File: doc/BRIEF.md
# Predicate Register File with Compare and Commit Gating

This block holds the one-bit predicates that qualify every instruction of a predicated pipeline, together with the compare unit that sets them and the gate that lets a functional-unit result reach architectural state. Each issued instruction names a qualifying predicate. A compare instruction tests two operands and writes a pair of complementary predicates. A non-compare instruction brings its result (destination index, value, valid) on the result-write interface in the same cycle it issues. The result is written back only when its qualifying predicate reads true.

An issued instruction is registered into an execute stage on the first clock edge. There its qualifier is resolved against the predicate store and against a pending compare write that has not yet reached the store. The commit decision and the write-back are registered on the second edge. A compare updates its targets on that same second edge, so the very next instruction already sees the new values. Two combinational read ports show the current predicate values, including any pending compare write.

Top module: `pred_commit_unit`

## Requirements
- R1: The file holds 64 one-bit predicates addressed by a 6-bit index, and each read port returns the current value of the indexed predicate, including the effect of a compare issued two or more cycles earlier.
- R2: Predicate 0 always reads 1. Compare writes that name index 0 are ignored, so an instruction qualified by index 0 always commits.
- R3: A compare whose qualifier is true writes its first target with 1 and its second target with 0 when the relation holds, and the reverse when it fails. The relation codes are 2'b00 equal, 2'b01 not equal, 2'b10 signed less-than, 2'b11 unsigned less-than.
- R4: For an instruction issued in cycle t, commit_en is 1 after the second rising edge exactly when its qualifier is true. In that same cycle, wb_en, wb_dst and wb_val carry the result only for a non-compare instruction with a true qualifier and result valid. Otherwise wb_en is 0 and wb_dst and wb_val are 0.
- R5: A compare whose qualifier is false writes neither target, and both keep their prior values.
- R6: After reset, predicates 1 to 63 read 0, predicate 0 reads 1, and commit_en and wb_en are 0.
- R7: An instruction issued in the cycle right after a compare is qualified by the value that compare writes.
- R8: When both compare targets name the same predicate, the first target's value is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | An instruction issues this cycle |
| iss_cmp | input | 1 | The issued instruction is a compare |
| iss_qp | input | 6 | Qualifying predicate index |
| iss_rel | input | 2 | Compare relation code |
| iss_opa | input | 64 | First compare operand |
| iss_opb | input | 64 | Second compare operand |
| iss_t1 | input | 6 | First compare target index |
| iss_t2 | input | 6 | Second compare target index |
| res_vld | input | 1 | Result valid for the issued non-compare instruction |
| res_dst | input | 7 | Result destination index |
| res_val | input | 64 | Result value |
| commit_en | output | 1 | Issued instruction committed |
| wb_en | output | 1 | Architectural write of a result |
| wb_dst | output | 7 | Write destination index |
| wb_val | output | 64 | Write value |
| rd_idx | input | 12 | Two packed 6-bit read indices, port 0 in bits 5:0 |
| rd_val | output | 2 | Read values, bit n for port n |

## Verification
The assertions assume that issue fields are stable and known whenever iss_vld is 1, and that reset is held for at least one edge before the first issue. Several assertions, such as the one that a squashed instruction leaves commit and write-back low, also assume that the execute stage is loaded only through iss_vld. The bench drives every field from tasks at the falling edge and parks all inputs at zero between instructions. It issues back-to-back pairs to test forwarding, and it reads the predicates through the read ports only after the pipeline has drained.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [1:0] {
    REL_EQ  = 2'b00,
    REL_NE  = 2'b01,
    REL_LT  = 2'b10,
    REL_LTU = 2'b11
  } rel_e;

  // complementary pair: {first target, second target}
  function automatic logic [1:0] pred_pair(input logic holds);
    return {holds, ~holds};
  endfunction

endpackage

// File: rtl/pcu_cmp.sv
module pcu_cmp #(
  parameter int DW = 64
) (
  input  logic [DW-1:0]     opa,
  input  logic [DW-1:0]     opb,
  input  pcu_pkg::rel_e     rel,
  output logic              holds
);
  import pcu_pkg::*;

  function automatic logic rel_eval(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                    input rel_e r);
    logic res;
    case (r)
      REL_EQ:  res = (a == b);
      REL_NE:  res = (a != b);
      REL_LT:  res = ($signed(a) < $signed(b));
      default: res = (a < b);
    endcase
    return res;
  endfunction

  assign holds = rel_eval(opa, opb, rel);

endmodule

// File: rtl/pcu_pfile.sv
module pcu_pfile #(
  parameter int NPRED = 64,
  parameter int NRD   = 2,
  localparam int PIW  = $clog2(NPRED)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pw_vld,
  input  logic [PIW-1:0]     pw_i1,
  input  logic               pw_v1,
  input  logic [PIW-1:0]     pw_i2,
  input  logic               pw_v2,
  input  logic [PIW-1:0]     qp_idx,
  output logic               qp_val,
  input  logic [NRD*PIW-1:0] rd_idx,
  output logic [NRD-1:0]     rd_val
);

  logic [NPRED-1:0] store;

  // pending write lands on the edge; second target first so the first wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store <= '0;
    end else if (pw_vld) begin
      if (pw_i2 != '0) store[pw_i2] <= pw_v2;
      if (pw_i1 != '0) store[pw_i1] <= pw_v1;
    end
  end

  // qualifier read with bypass of the pending compare write
  always_comb begin
    if (qp_idx == '0)                      qp_val = 1'b1;
    else if (pw_vld && (qp_idx == pw_i1))  qp_val = pw_v1;
    else if (pw_vld && (qp_idx == pw_i2))  qp_val = pw_v2;
    else                                   qp_val = store[qp_idx];
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [PIW-1:0] idx;
    assign idx = rd_idx[g*PIW +: PIW];
    always_comb begin
      if (idx == '0)                      rd_val[g] = 1'b1;
      else if (pw_vld && (idx == pw_i1))  rd_val[g] = pw_v1;
      else if (pw_vld && (idx == pw_i2))  rd_val[g] = pw_v2;
      else                                rd_val[g] = store[idx];
    end

    AST_P0_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == '0) |-> rd_val[g]); // R2
  end

  AST_PAIR_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    pw_vld |-> (pw_v1 != pw_v2)); // R3

  AST_P0_QUAL_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    (qp_idx == '0) |-> qp_val); // R2

endmodule

// File: rtl/pcu_gate.sv
module pcu_gate #(
  parameter int DW = 64,
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_valid,
  input  logic          x_is_cmp,
  input  logic          x_qual,
  input  logic          x_res_vld,
  input  logic [RW-1:0] x_dst,
  input  logic [DW-1:0] x_data,
  output logic          commit_en,
  output logic          wb_en,
  output logic [RW-1:0] wb_dst,
  output logic [DW-1:0] wb_val
);

  logic take, write;
  assign take  = x_valid & x_qual;
  assign write = take & ~x_is_cmp & x_res_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_en <= 1'b0;
      wb_en     <= 1'b0;
      wb_dst    <= '0;
      wb_val    <= '0;
    end else begin
      commit_en <= take;
      wb_en     <= write;
      wb_dst    <= write ? x_dst  : '0;
      wb_val    <= write ? x_data : '0;
    end
  end

  AST_FALSE_QUAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && !x_qual) |=> (!commit_en && !wb_en)); // R4

  AST_WB_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> commit_en); // R4

  AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && x_is_cmp) |=> !wb_en); // R4

endmodule

// File: rtl/pred_commit_unit.sv
module pred_commit_unit #(
  parameter int NPRED = 64,
  parameter int DW    = 64,
  parameter int RW    = 7,
  parameter int NRD   = 2,
  localparam int PIW  = $clog2(NPRED)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_vld,
  input  logic               iss_cmp,
  input  logic [PIW-1:0]     iss_qp,
  input  logic [1:0]         iss_rel,
  input  logic [DW-1:0]      iss_opa,
  input  logic [DW-1:0]      iss_opb,
  input  logic [PIW-1:0]     iss_t1,
  input  logic [PIW-1:0]     iss_t2,
  input  logic               res_vld,
  input  logic [RW-1:0]      res_dst,
  input  logic [DW-1:0]      res_val,
  output logic               commit_en,
  output logic               wb_en,
  output logic [RW-1:0]      wb_dst,
  output logic [DW-1:0]      wb_val,
  input  logic [NRD*PIW-1:0] rd_idx,
  output logic [NRD-1:0]     rd_val
);
  import pcu_pkg::*;

  // execute stage
  logic           x_valid, x_is_cmp, x_res_vld;
  logic [PIW-1:0] x_qp, x_t1, x_t2;
  rel_e           x_rel;
  logic [DW-1:0]  x_a, x_b, x_data;
  logic [RW-1:0]  x_dst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_valid   <= 1'b0;
      x_is_cmp  <= 1'b0;
      x_res_vld <= 1'b0;
      x_qp      <= '0;
      x_t1      <= '0;
      x_t2      <= '0;
      x_rel     <= REL_EQ;
      x_a       <= '0;
      x_b       <= '0;
      x_data    <= '0;
      x_dst     <= '0;
    end else begin
      x_valid   <= iss_vld;
      x_is_cmp  <= iss_vld & iss_cmp;
      x_res_vld <= iss_vld & res_vld;
      x_qp      <= iss_qp;
      x_t1      <= iss_t1;
      x_t2      <= iss_t2;
      x_rel     <= rel_e'(iss_rel);
      x_a       <= iss_opa;
      x_b       <= iss_opb;
      x_data    <= res_val;
      x_dst     <= res_dst;
    end
  end

  // events brought out for checking
  logic x_qual, cmp_holds, cmp_fire;
  logic [1:0] pair;

  pcu_cmp #(.DW(DW)) u_cmp (
    .opa   (x_a),
    .opb   (x_b),
    .rel   (x_rel),
    .holds (cmp_holds)
  );

  assign cmp_fire = x_valid & x_is_cmp & x_qual;
  assign pair     = pred_pair(cmp_holds);

  // pending compare write, forwarded by the file until it lands
  logic           pw_vld, pw_v1, pw_v2;
  logic [PIW-1:0] pw_i1, pw_i2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pw_vld <= 1'b0;
      pw_i1  <= '0;
      pw_i2  <= '0;
      pw_v1  <= 1'b0;
      pw_v2  <= 1'b1;
    end else begin
      pw_vld <= cmp_fire;
      pw_i1  <= x_t1;
      pw_i2  <= x_t2;
      pw_v1  <= pair[1];
      pw_v2  <= pair[0];
    end
  end

  pcu_pfile #(.NPRED(NPRED), .NRD(NRD)) u_pfile (
    .clk    (clk),
    .rst_n  (rst_n),
    .pw_vld (pw_vld),
    .pw_i1  (pw_i1),
    .pw_v1  (pw_v1),
    .pw_i2  (pw_i2),
    .pw_v2  (pw_v2),
    .qp_idx (x_qp),
    .qp_val (x_qual),
    .rd_idx (rd_idx),
    .rd_val (rd_val)
  );

  pcu_gate #(.DW(DW), .RW(RW)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .x_valid   (x_valid),
    .x_is_cmp  (x_is_cmp),
    .x_qual    (x_qual),
    .x_res_vld (x_res_vld),
    .x_dst     (x_dst),
    .x_data    (x_data),
    .commit_en (commit_en),
    .wb_en     (wb_en),
    .wb_dst    (wb_dst),
    .wb_val    (wb_val)
  );

  AST_SQUASHED_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && x_is_cmp && !x_qual) |=> !pw_vld); // R5

  AST_CMP_WRITES_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && x_is_cmp && x_qual) |=> (pw_vld && commit_en)); // R3

endmodule

// File: tb/sim_pred_commit_unit.sv
module sim_pred_commit_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_vld, iss_cmp, res_vld;
  logic [5:0]  iss_qp, iss_t1, iss_t2;
  logic [1:0]  iss_rel;
  logic [63:0] iss_opa, iss_opb, res_val;
  logic [6:0]  res_dst;
  logic        commit_en, wb_en;
  logic [6:0]  wb_dst;
  logic [63:0] wb_val;
  logic [11:0] rd_idx;
  logic [1:0]  rd_val;

  always #4 clk = ~clk;

  pred_commit_unit u0 (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_cmp(iss_cmp), .iss_qp(iss_qp),
    .iss_rel(iss_rel), .iss_opa(iss_opa), .iss_opb(iss_opb), .iss_t1(iss_t1),
    .iss_t2(iss_t2), .res_vld(res_vld), .res_dst(res_dst), .res_val(res_val),
    .commit_en(commit_en), .wb_en(wb_en), .wb_dst(wb_dst), .wb_val(wb_val),
    .rd_idx(rd_idx), .rd_val(rd_val)
  );

  typedef struct {
    int          due;
    logic        c;
    logic        w;
    logic [6:0]  d;
    logic [63:0] v;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   vectors = 0;
  int   fails = 0;
  bit   done = 0;
  bit   model [64];

  // monitor: compares outputs due after the second edge of each issue
  always @(posedge clk) begin
    #2;
    cyc++;
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (commit_en !== e.c || wb_en !== e.w || wb_dst !== e.d || wb_val !== e.v) begin
        fails++;
        $display("FAIL %s: got c=%b w=%b d=%0d v=%h exp c=%b w=%b d=%0d v=%h",
                 e.tag, commit_en, wb_en, wb_dst, wb_val, e.c, e.w, e.d, e.v);
      end
    end
  end

  function automatic bit rel_ref(input logic [1:0] r, input logic [63:0] a, input logic [63:0] b);
    if (r == 2'b00) return a == b;
    if (r == 2'b01) return a != b;
    if (r == 2'b10) return $signed(a) < $signed(b);
    return a < b;
  endfunction

  function automatic bit qual_of(input logic [5:0] i);
    return (i == 0) ? 1'b1 : model[i];
  endfunction

  task automatic park();
    iss_vld = 0; iss_cmp = 0; iss_qp = 0; iss_rel = 0; iss_opa = 0; iss_opb = 0;
    iss_t1 = 0; iss_t2 = 0; res_vld = 0; res_dst = 0; res_val = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    park();
  endtask

  task automatic drain();
    repeat (3) idle();
  endtask

  task automatic issue_cmp(input logic [5:0] qp, input logic [1:0] rel, input logic [63:0] a,
                           input logic [63:0] b, input logic [5:0] t1, input logic [5:0] t2,
                           input string tag);
    exp_t e;
    bit   ql, h;
    @(negedge clk);
    park();
    iss_vld = 1; iss_cmp = 1; iss_qp = qp; iss_rel = rel; iss_opa = a; iss_opb = b;
    iss_t1 = t1; iss_t2 = t2;
    ql = qual_of(qp);
    h  = rel_ref(rel, a, b);
    if (ql) begin
      if (t2 != 0) model[t2] = ~h;
      if (t1 != 0) model[t1] = h;
    end
    e.due = cyc + 2; e.c = ql; e.w = 0; e.d = 0; e.v = 0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic issue_op(input logic [5:0] qp, input logic rv, input logic [6:0] dst,
                          input logic [63:0] val, input string tag);
    exp_t e;
    bit   ql;
    @(negedge clk);
    park();
    iss_vld = 1; iss_qp = qp; res_vld = rv; res_dst = dst; res_val = val;
    ql = qual_of(qp);
    e.due = cyc + 2; e.c = ql; e.w = ql & rv;
    e.d = e.w ? dst : 7'd0; e.v = e.w ? val : 64'd0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check_rd(input logic [5:0] idx, input string tag);
    bit ex;
    rd_idx = {idx, idx};
    #1;
    ex = qual_of(idx);
    vectors++;
    if (rd_val !== {ex, ex}) begin
      fails++;
      $display("FAIL %s: p%0d read %b exp %b%b", tag, idx, rd_val, ex, ex);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    foreach (model[i]) model[i] = 0;
    park();
    rd_idx = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    drain();

    // R6 reset state, R1 all 64 entries
    vectors++;
    if (commit_en !== 1'b0 || wb_en !== 1'b0) begin
      fails++;
      $display("FAIL R6: c=%b w=%b exp 0 0", commit_en, wb_en);
    end
    for (int i = 0; i < 64; i++) check_rd(i[5:0], "R6_R1");

    // R3 each relation, true and false
    issue_cmp(0, 2'b00, 64'd5, 64'd5, 6'd3, 6'd4, "R3_eq");
    issue_cmp(0, 2'b01, 64'd5, 64'd5, 6'd5, 6'd6, "R3_ne");
    issue_cmp(0, 2'b10, -64'sd1, 64'd1, 6'd7, 6'd8, "R3_lt");
    issue_cmp(0, 2'b11, -64'sd1, 64'd1, 6'd9, 6'd12, "R3_ltu");
    drain();
    for (int i = 3; i <= 12; i++) check_rd(i[5:0], "R3_R1");

    // R4 gating of results
    issue_op(3, 1, 7'd17, 64'hDEAD_BEEF_0000_0001, "R4_true");
    issue_op(4, 1, 7'd18, 64'h1234, "R4_false");
    issue_op(3, 0, 7'd19, 64'h55, "R4_noresult");
    issue_op(0, 1, 7'd127, 64'hFFFF_FFFF_FFFF_FFFF, "R4_unpred");
    drain();

    // R5 squashed compare leaves targets
    issue_cmp(4, 2'b00, 64'd1, 64'd1, 6'd4, 6'd3, "R5_squash");
    drain();
    check_rd(3, "R5");
    check_rd(4, "R5");

    // R7 back-to-back forwarding
    issue_cmp(0, 2'b00, 64'd9, 64'd9, 6'd10, 6'd11, "R7_cmp");
    issue_op(10, 1, 7'd40, 64'hA5A5, "R7_fwd_true");
    issue_cmp(0, 2'b00, 64'd9, 64'd8, 6'd10, 6'd11, "R7_cmp2");
    issue_op(10, 1, 7'd41, 64'h5A5A, "R7_fwd_false");
    issue_op(11, 1, 7'd42, 64'h7777, "R7_fwd_other");
    drain();

    // R8 same target in both slots
    issue_cmp(0, 2'b00, 64'd2, 64'd2, 6'd20, 6'd20, "R8_hold");
    drain();
    check_rd(20, "R8");
    issue_cmp(0, 2'b00, 64'd2, 64'd3, 6'd20, 6'd20, "R8_fail");
    issue_op(20, 1, 7'd3, 64'h99, "R8_use");
    drain();
    check_rd(20, "R8");

    // R2 writes to p0 ignored
    issue_cmp(0, 2'b01, 64'd1, 64'd1, 6'd0, 6'd0, "R2_cmp");
    issue_op(0, 1, 7'd1, 64'h11, "R2_use");
    drain();
    check_rd(0, "R2");

    // mixed stream over many indices (R1, R3, R4, R7)
    for (int k = 0; k < 150; k++) begin
      logic [5:0] a1, a2, qp;
      a1 = 6'($urandom_range(1, 63));
      a2 = 6'($urandom_range(1, 63));
      qp = 6'($urandom_range(0, 63));
      if (k % 3 == 0)
        issue_cmp(qp, 2'($urandom), 64'($urandom_range(0, 3)), 64'($urandom_range(0, 3)),
                  a1, a2, "R3_mix");
      else
        issue_op(qp, 1'($urandom), 7'($urandom), {$urandom, $urandom}, "R4_mix");
    end
    drain();
    for (int i = 0; i < 64; i++) check_rd(i[5:0], "R1_final");

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule